// File: doc/BRIEF.md
# Rate Generator With Toggle Flag

This block is a programmable periodic divider driven by a slow tick enable of about 1.193 MHz, one tick every 838 ns or so. That tick comes from a 14.31818 MHz reference, and the block sees it as a one-cycle enable in its own clock domain. Software writes an initial count. On the first tick after that write, the count is placed in a down-counter. The counter then steps down by one per tick. While it holds the value one, the block drives a pulse that lasts one tick interval. On the tick that follows, it reloads the initial count and runs again.

The software-visible result is a status bit, not the pulse. The bit inverts each time a pulse ends, so it forms a square wave with a period of twice the count in ticks, and a status read can poll it. A count of zero stands for 65536. A count of one is refused. The block always runs as a rate generator, and no other operating mode exists.

Top module: `rate_toggle_gen`

## Requirements
- R1: While reset is asserted and directly after it, `rate_pulse` and `toggle_flag` are both 0.
- R2: Until a legal count has been loaded, tick enables produce no pulse and `toggle_flag` stays at 0.
- R3: A legal written count is taken into the counter on the first `tick_en` cycle strictly after the write cycle. A tick in the same cycle as any write does not load.
- R4: With a loaded count N (N at least 2), `rate_pulse` is 1 for exactly the tick interval that starts N-1 ticks after the load tick, and repeats every N ticks after that. It is never high across two consecutive ticks.
- R5: `toggle_flag` inverts on each tick that ends a pulse and never changes otherwise, so its period is 2N ticks. Between ticks, neither output changes.
- R6: A written count of 0 gives a period of 65536 ticks.
- R7: A write of the value 1 is ignored. An idle block stays idle, and a running block keeps its count and phase.
- R8: A legal write while the counter runs restarts the period with the new count at the next tick. If that tick also ends a pulse, `toggle_flag` still inverts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle counting enable, about every 838 ns |
| wr_en | input | 1 | Software write strobe for the initial count |
| wr_count | input | CNT_W | Initial count value (0 means 2^CNT_W, 1 is refused) |
| rate_pulse | output | 1 | High for one tick interval at each terminal count |
| toggle_flag | output | 1 | Status bit that inverts at the end of each pulse |

## Verification
The terminal-count reload and the load of a newly written count can land on the same tick. The bench provokes this by waiting until `rate_pulse` is high, writing a new count, and then issuing one tick. At that tick the flag must still invert, and the next pulse must follow the new count instead of the old one. A second case puts the write and a tick in the same cycle: the pulse timing shows that the load waited for the following tick.

// File: rtl/rg_pkg.sv
package rg_pkg;
   localparam int unsigned RG_MIN_W = 2;
   localparam int unsigned RG_MAX_W = 32;

   typedef enum logic {
      RG_IDLE = 1'b0,
      RG_RUN  = 1'b1
   } rg_state_e;
endpackage

// File: rtl/rg_count_latch.sv
module rg_count_latch #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_count,
   output logic [CNT_W-1:0] init_q,
   output logic             load_pend,
   output logic             load_now
);
   localparam logic [CNT_W-1:0] BAD_COUNT = CNT_W'(1);

   logic accept;

   assign accept   = wr_en && (wr_count != BAD_COUNT);
   assign load_now = tick_en && load_pend && !wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q    <= '0;
         load_pend <= 1'b0;
      end else if (accept) begin
         init_q    <= wr_count;
         load_pend <= 1'b1;
      end else if (load_now) begin
         load_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/rg_down_counter.sv
module rg_down_counter
   import rg_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load_now,
   input  logic [CNT_W-1:0] init_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             running,
   output logic             at_term
);
   localparam logic [CNT_W-1:0] TERM_VAL = CNT_W'(1);

   rg_state_e state_q;

   assign running = (state_q == RG_RUN);
   assign at_term = running && (cnt_q == TERM_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RG_IDLE;
         cnt_q   <= '0;
      end else if (tick_en) begin
         if (load_now) begin
            state_q <= RG_RUN;
            cnt_q   <= init_q;
         end else if (at_term) begin
            cnt_q   <= init_q;
         end else if (running) begin
            cnt_q   <= cnt_q - TERM_VAL;
         end
      end
   end
endmodule

// File: rtl/rg_toggle_flag.sv
module rg_toggle_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic at_term,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (tick_en && at_term)
         flag_q <= ~flag_q;
   end
endmodule

// File: rtl/rate_toggle_gen.sv
module rate_toggle_gen
   import rg_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_count,
   output logic             rate_pulse,
   output logic             toggle_flag
);
   generate
      if (CNT_W < RG_MIN_W || CNT_W > RG_MAX_W) begin : g_bad_width
         initial $fatal(1, "rate_toggle_gen: CNT_W %0d out of range", CNT_W);
      end
   endgenerate

   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] cnt_q;
   logic             load_pend;
   logic             load_now;
   logic             running;
   logic             at_term;

   rg_count_latch #(.CNT_W(CNT_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .wr_en     (wr_en),
      .wr_count  (wr_count),
      .init_q    (init_q),
      .load_pend (load_pend),
      .load_now  (load_now)
   );

   rg_down_counter #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .load_now (load_now),
      .init_q   (init_q),
      .cnt_q    (cnt_q),
      .running  (running),
      .at_term  (at_term)
   );

   rg_toggle_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .at_term (at_term),
      .flag_q  (toggle_flag)
   );

   assign rate_pulse = at_term;
endmodule

// File: rtl/rate_toggle_gen_chk.sv
module rate_toggle_gen_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_count,
   input logic             rate_pulse,
   input logic             toggle_flag,
   input logic             running,
   input logic             load_pend,
   input logic [CNT_W-1:0] init_q,
   input logic [CNT_W-1:0] cnt_q
);
   always @(negedge clk) begin
      if (!rst_n) begin
         a_reset_outputs_r1: assert (!rate_pulse && !toggle_flag)
            else $error("outputs not cleared in reset");
      end
   end

   p_idle_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!toggle_flag && !rate_pulse));

   p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && load_pend && !wr_en) |=> (cnt_q == $past(init_q)));

   p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && rate_pulse) |=> !rate_pulse);

   p_flag_inverts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && rate_pulse) |=> (toggle_flag != $past(toggle_flag)));

   p_flag_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_en && rate_pulse) |=> $stable(toggle_flag));

   p_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(rate_pulse));

   p_refuse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_count == CNT_W'(1) && !tick_en) |=>
         ($stable(init_q) && $stable(load_pend)));
endmodule

bind rate_toggle_gen rate_toggle_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .wr_en       (wr_en),
   .wr_count    (wr_count),
   .rate_pulse  (rate_pulse),
   .toggle_flag (toggle_flag),
   .running     (running),
   .load_pend   (load_pend),
   .init_q      (init_q),
   .cnt_q       (cnt_q)
);

// File: tb/rate_toggle_gen_tb.sv
module rate_toggle_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int NVEC       = 4;
   localparam int VEC_CNT   [NVEC] = '{5, 2, 3, 7};
   localparam int VEC_TICKS [NVEC] = '{12, 6, 9, 15};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_en = 1'b0;
   logic             wr_en = 1'b0;
   logic [CNT_W-1:0] wr_count = '0;
   logic             rate_pulse;
   logic             toggle_flag;

   int n_checks = 0;
   int n_fail   = 0;
   logic base;

   always #(CLK_PERIOD/2) clk = ~clk;

   rate_toggle_gen #(.CNT_W(CNT_W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .wr_en       (wr_en),
      .wr_count    (wr_count),
      .rate_pulse  (rate_pulse),
      .toggle_flag (toggle_flag)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_write(input int val);
      @(negedge clk);
      wr_en = 1'b1; wr_count = CNT_W'(val);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 pulse in reset", rate_pulse, 1'b0);
      chk("R1 flag in reset", toggle_flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pulse after reset", rate_pulse, 1'b0);
      chk("R1 flag after reset", toggle_flag, 1'b0);

      // R2: ticks before any load
      for (int i = 0; i < 4; i++) begin
         do_tick();
         chk("R2 idle pulse", rate_pulse, 1'b0);
         chk("R2 idle flag", toggle_flag, 1'b0);
      end

      // R7: write of 1 while idle is ignored
      do_write(1);
      for (int i = 0; i < 4; i++) begin
         do_tick();
         chk("R7 idle after refused write", rate_pulse | toggle_flag, 1'b0);
      end

      // R3: a tick in the write cycle does not load (count 2)
      @(negedge clk);
      wr_en = 1'b1; tick_en = 1'b1; wr_count = CNT_W'(2);
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
      chk("R3 no load on write tick", rate_pulse, 1'b0);
      do_tick();   // load tick, k=0
      chk("R3 k0 pulse low", rate_pulse, 1'b0);
      do_tick();   // k=1 -> pulse
      chk("R3 k1 pulse high", rate_pulse, 1'b1);
      do_tick();   // k=2 -> flag inverted
      chk("R3 first flag edge", toggle_flag, 1'b1);

      // R4/R5: table of counts walked by one loop
      for (int v = 0; v < NVEC; v++) begin
         int n;
         n = VEC_CNT[v];
         do_write(n);
         do_tick();
         base = toggle_flag;
         chk("R3 load tick pulse low", rate_pulse, 1'b0);
         for (int k = 1; k <= VEC_TICKS[v]; k++) begin
            do_tick();
            chk("R4 pulse timing", rate_pulse, ((k % n) == n - 1));
            chk("R5 flag timing", toggle_flag, base ^ logic'((k / n) % 2));
         end
      end

      // R5: between ticks outputs stay put
      do_write(3);
      do_tick();
      do_tick();
      do_tick();   // k=2 pulse high
      repeat (5) @(negedge clk);
      chk("R5 pulse held between ticks", rate_pulse, 1'b1);

      // R7: write of 1 while running keeps count and phase (count 4)
      do_write(4);
      do_tick();   // k=0
      base = toggle_flag;
      do_tick();   // k=1
      do_tick();   // k=2
      do_write(1);
      do_tick();   // k=3
      chk("R7 pulse kept after refused write", rate_pulse, 1'b1);
      do_tick();   // k=4
      chk("R7 flag kept phase", toggle_flag, ~base);
      do_tick(); do_tick(); do_tick();   // k=7
      chk("R7 period still 4", rate_pulse, 1'b1);

      // R8: new count on the same tick as a terminal count
      base = toggle_flag;
      do_write(6);
      do_tick();   // reload from new count, pulse ends
      chk("R8 flag inverts on coincident load", toggle_flag, ~base);
      chk("R8 pulse ends", rate_pulse, 1'b0);
      for (int k = 1; k <= 5; k++) begin
         do_tick();
         chk("R8 new period pulse", rate_pulse, (k == 5));
      end

      // R8: mid-period write restarts without toggling (count 4 then 3)
      do_write(4);
      do_tick();
      do_tick();   // k=1 of count 4
      base = toggle_flag;
      do_write(3);
      do_tick();   // load of 3
      chk("R8 no toggle on mid load", toggle_flag, base);
      do_tick();
      chk("R8 restart k1", rate_pulse, 1'b0);
      do_tick();
      chk("R8 restart k2 pulse", rate_pulse, 1'b1);

      // R6: count 0 means 65536 ticks, tick held every cycle
      do_write(0);
      @(negedge clk);
      tick_en = 1'b1;
      for (int k = 0; k <= 65536; k++) begin
         @(negedge clk);
         if (k == 0) base = toggle_flag;
         if (k == 65534) chk("R6 no pulse early", rate_pulse, 1'b0);
         if (k == 65535) begin
            chk("R6 pulse at 65535", rate_pulse, 1'b1);
            chk("R6 flag before end", toggle_flag, base);
         end
         if (k == 65536) begin
            chk("R6 flag after 65536", toggle_flag, ~base);
            chk("R6 pulse ended", rate_pulse, 1'b0);
         end
      end
      tick_en = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule